// File: doc/BRIEF.md
# Full-speed USB receive byte assembler with bit unstuffing

This block sits behind a full-speed USB receive front end that has already done clock recovery, NRZI decoding and sync/EOP detection. It takes one decoded bit per bit strobe while a packet-active level is high. It drops the zero that a transmitter inserts after every run of six ones, and it flags a missing stuff bit as an error. The remaining data bits are packed least-significant-bit first into bytes.

Each finished byte is offered on a parallel bus with a receive-valid qualifier. The qualifier is a single-clock pulse, not a level. A small controller walks through idle, data and wait states. It also keeps a running count of removed stuff bits. Every time that count completes a full group, the controller spends one whole byte time in the wait state with the qualifier held low. A byte that finishes during that window is offered once the window ends.

The front end is assumed to space bit strobes at least five clocks apart, which is the nominal full-speed bit period.

Top module: `rx_byte_asm`

## Requirements
- R1: When six consecutive 1 bits have been accepted, a following 0 bit is removed and does not become part of any byte.
- R2: When six consecutive 1 bits are followed by another 1, `rx_error_o` is high for exactly the one clock that follows the edge at which that strobe is sampled.
- R3: After a stuffing error, no `rx_valid_o` pulse and no further error pulse appear until `pkt_active_i` falls. The next packet is then received normally.
- R4: Data bits fill a byte from bit 0 upward, and a byte is complete after 8 data bits. Unless a wait window is pending, `rx_valid_o` rises in the second clock after the edge of the completing strobe. `rx_data_o` carries that byte while `rx_valid_o` is high.
- R5: `rx_valid_o` is low after reset and is never high for two clocks in a row. There is exactly one pulse per received byte.
- R6: Removed stuff bits are counted whether or not they are adjacent. On the eighth one, the controller holds `rx_valid_o` low for BYTE_CLKS clocks (40 by default). A byte completed during that window is presented right after it, and the count restarts from zero.
- R7: While `pkt_active_i` is low, strobes are ignored. When `pkt_active_i` falls, the partial byte, the ones run, the stuff count and any pending byte or wait are discarded.
- R8: A data 0 bit, or a removed stuff 0, restarts the count of consecutive ones. A run of five ones, then a 0, then more ones therefore contains no stuff bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_active_i | input | 1 | High while a packet is being received |
| rx_bit_i | input | 1 | Decoded serial bit, sampled on a strobe |
| bit_stb_i | input | 1 | One-clock strobe marking a new bit |
| rx_data_o | output | DATA_W (8) | Assembled byte |
| rx_valid_o | output | 1 | One-clock pulse, byte on `rx_data_o` is valid |
| rx_error_o | output | 1 | One-clock pulse on a bit-stuffing violation |

## Verification
The bench uses the default parameters: 8-bit bytes, a ones run of six, a skip after eight stuff bits and a 40-clock wait window. Bits arrive every five clocks, as at full speed. With those values, a string of bytes that each hold exactly one stuff bit places the eighth stuff bit two bits before a byte ends. The wait window then visibly delays that byte's pulse by about 30 clocks, so a missing or miscounted skip is caught. A ninth such byte shows that the count restarted. A behavioural model predicts the valid, error and data outputs clock by clock. Directed packets cover stuffing errors, aborted packets and strobes while idle.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_WAIT = 2'd2,
    ST_HALT = 2'd3
  } rxa_state_e;
endpackage

// File: rtl/rxa_unstuff.sv
module rxa_unstuff #(
  parameter int RUN_LEN     = 6,
  parameter int STUFF_LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stb_i,
  input  logic bit_i,
  output logic data_stb_o,
  output logic err_o,
  output logic skip_o
);
  localparam int OW = $clog2(RUN_LEN + 1);
  localparam int SW = $clog2(STUFF_LIMIT);

  logic [OW-1:0] ones_q;
  logic [SW-1:0] stuff_q;
  logic          at_run;
  logic          stuff;

  assign at_run     = (ones_q == OW'(RUN_LEN));
  assign data_stb_o = stb_i & ~at_run;
  assign stuff      = stb_i & at_run & ~bit_i;
  assign err_o      = stb_i & at_run & bit_i;
  assign skip_o     = stuff & (stuff_q == SW'(STUFF_LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q  <= '0;
      stuff_q <= '0;
    end else if (clr_i) begin
      ones_q  <= '0;
      stuff_q <= '0;
    end else begin
      if (data_stb_o) ones_q <= bit_i ? ones_q + 1'b1 : '0;
      else if (stuff) ones_q <= '0;
      if (stuff) stuff_q <= skip_o ? '0 : stuff_q + 1'b1;
    end
  end

  // R1
  ones_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= OW'(RUN_LEN));

  // R8
  run_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && stb_i && !bit_i) |=> (ones_q == '0));
endmodule

// File: rtl/rxa_shift.sv
module rxa_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              stb_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  localparam int PW = $clog2(DATA_W);

  logic [PW-1:0]     pos_q;
  logic [DATA_W-1:0] sh_q;

  assign done_o = stb_i & (pos_q == PW'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      sh_q   <= '0;
      data_o <= '0;
    end else if (clr_i) begin
      pos_q <= '0;
      sh_q  <= '0;
    end else if (stb_i) begin
      sh_q[pos_q] <= bit_i;
      pos_q       <= done_o ? '0 : pos_q + 1'b1;
      if (done_o) data_o <= {bit_i, sh_q[DATA_W-2:0]};
    end
  end

  // R4
  msb_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> (data_o[DATA_W-1] == $past(bit_i)));
endmodule

// File: rtl/rxa_ctrl.sv
module rxa_ctrl
  import rxa_pkg::*;
#(
  parameter int BYTE_CLKS = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic done_i,
  input  logic skip_i,
  input  logic err_i,
  output logic valid_o,
  output logic error_o,
  output logic halt_o
);
  localparam int WW = $clog2(BYTE_CLKS);

  rxa_state_e    state_q, state_d;
  logic          rdy_q, rdy_d;
  logic          skip_q, skip_d;
  logic [WW-1:0] wait_q, wait_d;
  logic          err_q;

  always_comb begin
    state_d = state_q;
    rdy_d   = rdy_q;
    skip_d  = skip_q;
    wait_d  = wait_q;
    unique case (state_q)
      ST_IDLE: begin
        if (skip_q) begin
          state_d = ST_WAIT;
          skip_d  = 1'b0;
          wait_d  = WW'(BYTE_CLKS - 1);
        end else if (rdy_q) begin
          state_d = ST_DATA;
          rdy_d   = 1'b0;
        end
      end
      ST_DATA: state_d = ST_IDLE;
      ST_WAIT: begin
        if (wait_q == '0) state_d = ST_IDLE;
        else              wait_d  = wait_q - 1'b1;
      end
      default: ;
    endcase
    if (done_i) rdy_d  = 1'b1;
    if (skip_i) skip_d = 1'b1;
    if (err_i) begin
      state_d = ST_HALT;
      rdy_d   = 1'b0;
      skip_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rdy_q   <= 1'b0;
      skip_q  <= 1'b0;
      wait_q  <= '0;
      err_q   <= 1'b0;
    end else if (!active_i) begin
      state_q <= ST_IDLE;
      rdy_q   <= 1'b0;
      skip_q  <= 1'b0;
      wait_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rdy_q   <= rdy_d;
      skip_q  <= skip_d;
      wait_q  <= wait_d;
      err_q   <= err_i;
    end
  end

  assign valid_o = (state_q == ST_DATA);
  assign error_o = err_q;
  assign halt_o  = (state_q == ST_HALT);

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R2
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !error_o);

  // R6
  wait_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |=> !valid_o);

  // R7
  inactive_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (!valid_o && !error_o));
endmodule

// File: rtl/rx_byte_asm.sv
module rx_byte_asm #(
  parameter int DATA_W      = 8,
  parameter int RUN_LEN     = 6,
  parameter int STUFF_LIMIT = 8,
  parameter int BYTE_CLKS   = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_active_i,
  input  logic              rx_bit_i,
  input  logic              bit_stb_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_error_o
);
  logic halt, stb_q, clr;
  logic data_stb, err, skip, done;

  assign clr   = ~pkt_active_i;
  assign stb_q = bit_stb_i & pkt_active_i & ~halt;

  rxa_unstuff #(.RUN_LEN(RUN_LEN), .STUFF_LIMIT(STUFF_LIMIT)) u_unstuff (
    .clk_i, .rst_ni, .clr_i(clr), .stb_i(stb_q), .bit_i(rx_bit_i),
    .data_stb_o(data_stb), .err_o(err), .skip_o(skip)
  );

  rxa_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .clr_i(clr), .stb_i(data_stb), .bit_i(rx_bit_i),
    .data_o(rx_data_o), .done_o(done)
  );

  rxa_ctrl #(.BYTE_CLKS(BYTE_CLKS)) u_ctrl (
    .clk_i, .rst_ni, .active_i(pkt_active_i), .done_i(done), .skip_i(skip),
    .err_i(err), .valid_o(rx_valid_o), .error_o(rx_error_o), .halt_o(halt)
  );

  // R3
  halt_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && pkt_active_i) |=> !rx_valid_o);
endmodule

// File: tb/rx_byte_asm_tb_top.sv
module rx_byte_asm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, RUN = 6, LIM = 8, BCLK = 40, BIT_CLKS = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pkt_active = 1'b0, rx_bit = 1'b0, bit_stb = 1'b0;
  logic [DW-1:0] rx_data;
  logic rx_valid, rx_error;

  rx_byte_asm dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pkt_active_i(pkt_active),
    .rx_bit_i(rx_bit), .bit_stb_i(bit_stb),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_error_o(rx_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_ones = 0, m_pos = 0, m_stuff = 0, m_mode = 0, m_wait = 0;
  bit m_skip = 0, exp_valid = 0, exp_err = 0;
  logic [7:0] m_sh = '0, m_out = '0;
  logic [7:0] m_q[$];

  always @(posedge clk) begin
    bit stb, e, st, d;
    if (!rst_ni || !pkt_active) begin
      m_ones = 0; m_pos = 0; m_stuff = 0; m_mode = 0; m_wait = 0;
      m_skip = 0; m_q.delete(); exp_valid = 0; exp_err = 0;
    end else begin
      stb = bit_stb && (m_mode != 3);
      e   = stb && (m_ones == RUN) && rx_bit;
      st  = stb && (m_ones == RUN) && !rx_bit;
      d   = stb && (m_ones < RUN);
      exp_err = e;
      if (e) begin
        m_mode = 3; m_q.delete(); m_skip = 0;
      end else begin
        case (m_mode)
          0: if (m_skip) begin m_mode = 2; m_skip = 0; m_wait = BCLK; end
             else if (m_q.size() > 0) begin m_mode = 1; m_out = m_q.pop_front(); end
          1: m_mode = 0;
          2: begin m_wait--; if (m_wait == 0) m_mode = 0; end
          default: ;
        endcase
        if (d) begin
          m_sh[m_pos] = rx_bit;
          m_ones = rx_bit ? m_ones + 1 : 0;
          m_pos++;
          if (m_pos == DW) begin m_q.push_back(m_sh); m_pos = 0; end
        end
        if (st) begin
          m_ones = 0; m_stuff++;
          if (m_stuff == LIM) begin m_stuff = 0; m_skip = 1; end
        end
      end
      exp_valid = (m_mode == 1);
    end
  end

  // per-clock comparison and monitor
  int mon_valid = 0, mon_err = 0, gap = 0, max_gap = 0;
  logic [7:0] last_byte = '0;
  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R5 rx_valid", rx_valid, exp_valid);
      chk("R2 rx_error", rx_error, exp_err);
      if (exp_valid && rx_valid) chk("R4 rx_data", rx_data, m_out);
      gap++;
      if (rx_valid) begin
        mon_valid++; last_byte = rx_data;
        if (gap > max_gap) max_gap = gap;
        gap = 0;
      end
      if (rx_error) mon_err++;
    end
  end

  int enc_run = 0;
  task automatic send_bit(bit b);
    @(negedge clk); rx_bit = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    repeat (BIT_CLKS-2) @(negedge clk);
  endtask
  task automatic send_enc(bit b);
    send_bit(b);
    if (b) begin
      enc_run++;
      if (enc_run == RUN) begin send_bit(1'b0); enc_run = 0; end
    end else enc_run = 0;
  endtask
  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_enc(v[i]);
  endtask
  task automatic pkt_on();
    @(negedge clk); pkt_active = 1'b1; enc_run = 0;
    repeat (2) @(negedge clk);
    gap = 0; max_gap = 0;
  endtask
  task automatic pkt_off();
    repeat (8) @(negedge clk); pkt_active = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int v0, e0;
    repeat (3) @(negedge clk);
    chk("R5 reset valid", rx_valid, 0);
    chk("R2 reset error", rx_error, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R4 plain bytes
    pkt_on(); v0 = mon_valid;
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h00); send_byte(8'h81);
    pkt_off();
    chk("R4 byte count", mon_valid - v0, 4);
    chk("R4 last byte", last_byte, 8'h81);

    // R1 stuffed bytes
    pkt_on(); v0 = mon_valid; e0 = mon_err;
    send_byte(8'hFF); send_byte(8'h7E); send_byte(8'hFF); send_byte(8'h01);
    pkt_off();
    chk("R1 byte count", mon_valid - v0, 4);
    chk("R1 last byte", last_byte, 8'h01);
    chk("R1 no error", mon_err - e0, 0);

    // R6 one stuff per byte, eighth triggers the wait window
    pkt_on(); v0 = mon_valid;
    for (int k = 0; k < 9; k++) send_byte(8'h3F);
    pkt_off();
    chk("R6 byte count", mon_valid - v0, 9);
    chk("R6 skip visible", (max_gap > 60) ? 1 : 0, 1);
    chk("R6 last byte", last_byte, 8'h3F);

    // R2/R3 missing stuff bit
    pkt_on(); v0 = mon_valid; e0 = mon_err;
    for (int k = 0; k < 7; k++) send_bit(1'b1);
    send_byte(8'h3C); send_byte(8'hFF);
    pkt_off();
    chk("R2 error pulses", mon_err - e0, 1);
    chk("R3 no bytes after error", mon_valid - v0, 0);
    pkt_on(); v0 = mon_valid;
    send_byte(8'h5A);
    pkt_off();
    chk("R3 resume count", mon_valid - v0, 1);
    chk("R3 resume byte", last_byte, 8'h5A);

    // R7 aborted packet with partial ones run, then idle strobes
    pkt_on(); v0 = mon_valid;
    for (int k = 0; k < 5; k++) send_bit(1'b1);
    pkt_off();
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    pkt_on();
    send_byte(8'h03);
    pkt_off();
    chk("R7 byte count", mon_valid - v0, 1);
    chk("R7 byte after abort", last_byte, 8'h03);

    // R8 zero breaks the ones run
    pkt_on(); v0 = mon_valid;
    send_byte(8'hDF); send_byte(8'hFB); send_byte(8'hDF);
    pkt_off();
    chk("R8 byte count", mon_valid - v0, 3);
    chk("R8 last byte", last_byte, 8'hDF);

    report();
  end
endmodule